// File: doc/BRIEF.md
# Multi-Mode High-Speed Pulse Counter

This block counts fast digital pulses into a signed accumulator whose width defaults to 16 bits (-32768 to +32767). A three-bit mode input picks one of four counting families: count-up only, count with a direction level, separate increment and decrement pulses, and x1 quadrature decoding of an A/B channel pair. Each family has a plain variant and a variant in which two more pins act as an external zeroing edge and a counting hold level. The four input pins pass through a two-flop synchronizer on the system clock, and edges are detected from the synchronized levels. The accumulator changes by at most one count per clock.

In the count-up families the accumulator returns to zero when it reaches the high preset. In the bidirectional families the accumulator counts freely through both presets, and two registered flags track its position relative to them. Overflow and underflow wraps each raise a single-cycle event. A preload strobe writes any value into the accumulator. An enable input gates counting only: preload, zeroing and the compare flags keep working while it is low.

Top module: `hs_pulse_counter`

## Requirements
- R1: After reset the accumulator is 0, and `hi_flag`, `lo_flag`, `ovf` and `unf` are all 0.
- R2: Mode value 0 (up) adds one per rising edge on pin 0. The new value appears on `acc` three clock edges after the pin changes. Pins 1 to 3 have no effect in this mode.
- R3: In the up modes (mode values 0 and 1), an increment that would make the accumulator equal to `hi_preset` sets it to 0 instead.
- R4: In the direction modes (mode values 2 and 3), a rising edge on pin 0 adds one when pin 1 is low and subtracts one when pin 1 is high.
- R5: In the up/down modes (mode values 4 and 5), a rising edge on pin 0 adds one and a rising edge on pin 1 subtracts one. Edges on both pins in the same cycle leave the accumulator unchanged.
- R6: In the quadrature modes (mode values 6 and 7), a rising edge on pin 0 (A) adds one when pin 1 (B) is low and subtracts one when B is high. Edges on B alone do not count.
- R7: In the odd mode values (1, 3, 5, 7), a rising edge on pin 2 sets the accumulator to 0. This works even while `en` is low. In the even mode values, pin 2 has no effect.
- R8: In the odd mode values, counting is blocked for as long as pin 3 is high. In the even mode values, pin 3 has no effect.
- R9: While `en` is low the accumulator does not count. The compare flags still follow preset changes, and they update one edge after such a change.
- R10: In the bidirectional modes (mode values 2 to 7), `hi_flag` is 1 exactly when acc >= `hi_preset` and `lo_flag` is 1 exactly when acc <= `lo_preset`, both compared as signed values. In the up modes both flags are 0. The flags update on the same edge as the accumulator.
- R11: Adding one at the maximum positive value wraps to the minimum negative value, and `ovf` is high for exactly that one cycle.
- R12: Subtracting one at the minimum value wraps to the maximum, and `unf` is high for exactly that one cycle.
- R13: A `load` strobe writes `load_val` into the accumulator on the next edge. It takes priority over zeroing and counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Counting enable |
| mode | input | 3 | Counting mode: bits 2:1 select the family (0 up, 1 direction, 2 up/down, 3 quadrature), bit 0 enables the external zero and hold pins |
| pins | input | 4 | Raw input pins 0 to 3 |
| hi_preset | input | ACC_W | Signed high preset |
| lo_preset | input | ACC_W | Signed low preset |
| load | input | 1 | Accumulator preload strobe |
| load_val | input | ACC_W | Signed preload value |
| acc | output | ACC_W | Signed accumulator |
| hi_flag | output | 1 | Accumulator at or above the high preset (bidirectional modes) |
| lo_flag | output | 1 | Accumulator at or below the low preset (bidirectional modes) |
| ovf | output | 1 | One-cycle overflow wrap event |
| unf | output | 1 | One-cycle underflow wrap event |

## Verification
A pin change takes three clock edges to reach the accumulator: two synchronizer flops, then the accumulator register. The flags and the wrap events register on that same third edge. A preload or a preset change shows up one edge later. The bench drives inputs on falling edges. For the latency and wrap cases it samples exactly on the falling edge after the second and after the third rising edge, so an early or late result shows up as a mismatch. All other scenarios hold each pin pulse for two cycles and then wait four more, so every check samples settled values.

// File: rtl/hspc_pkg.sv
package hspc_pkg;

    typedef enum logic [1:0] {
        FAM_UP   = 2'd0,
        FAM_DIR  = 2'd1,
        FAM_UPDN = 2'd2,
        FAM_QUAD = 2'd3
    } family_e;

    // Pin role indices
    localparam int PIN_CNT  = 0;
    localparam int PIN_AUX  = 1;
    localparam int PIN_ZERO = 2;
    localparam int PIN_HOLD = 3;
    localparam int NUM_PINS = 4;

    typedef struct packed {
        logic inc;
        logic dec;
        logic zero;
        logic hold;
    } step_req_t;

endpackage

// File: rtl/hspc_sync.sv
module hspc_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    localparam int LAST = STAGES - 1;

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        logic              prev_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain_q <= '0;
                prev_q  <= 1'b0;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], raw[b]};
                prev_q  <= chain_q[LAST];
            end
        end

        assign lvl[b]  = chain_q[LAST];
        assign rise[b] = chain_q[LAST] & ~prev_q;
    end
endmodule

// File: rtl/hspc_decode.sv
module hspc_decode
    import hspc_pkg::*;
(
    input  logic [2:0]          mode,
    input  logic [NUM_PINS-1:0] lvl,
    input  logic [NUM_PINS-1:0] rise,
    output step_req_t           req
);
    family_e fam;
    logic    ext;

    always_comb begin
        fam = family_e'(mode[2:1]);
        ext = mode[0];
        req = '0;
        unique case (fam)
            FAM_UP: begin
                req.inc = rise[PIN_CNT];
            end
            FAM_DIR, FAM_QUAD: begin
                req.inc = rise[PIN_CNT] & ~lvl[PIN_AUX];
                req.dec = rise[PIN_CNT] &  lvl[PIN_AUX];
            end
            FAM_UPDN: begin
                req.inc = rise[PIN_CNT] & ~rise[PIN_AUX];
                req.dec = rise[PIN_AUX] & ~rise[PIN_CNT];
            end
            default: req = '0;
        endcase
        if (ext) begin
            req.zero = rise[PIN_ZERO];
            req.hold = lvl[PIN_HOLD];
        end
    end
endmodule

// File: rtl/hs_pulse_counter.sv
module hs_pulse_counter
    import hspc_pkg::*;
#(
    parameter int ACC_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic [2:0]              mode,
    input  logic [3:0]              pins,
    input  logic signed [ACC_W-1:0] hi_preset,
    input  logic signed [ACC_W-1:0] lo_preset,
    input  logic                    load,
    input  logic signed [ACC_W-1:0] load_val,
    output logic signed [ACC_W-1:0] acc,
    output logic                    hi_flag,
    output logic                    lo_flag,
    output logic                    ovf,
    output logic                    unf
);
    localparam logic signed [ACC_W-1:0] ACC_MAX = $signed({1'b0, {(ACC_W-1){1'b1}}});
    localparam logic signed [ACC_W-1:0] ACC_MIN = $signed({1'b1, {(ACC_W-1){1'b0}}});

    typedef struct packed {
        logic signed [ACC_W-1:0] acc;
        logic                    hi;
        logic                    lo;
        logic                    ovf;
        logic                    unf;
    } cnt_state_t;

    logic [NUM_PINS-1:0] pin_lvl;
    logic [NUM_PINS-1:0] pin_rise;
    step_req_t           req;
    cnt_state_t          st_d, st_q;
    logic                bidir;
    logic signed [ACC_W-1:0] up_val;
    logic signed [ACC_W-1:0] dn_val;

    hspc_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  (pins),
        .lvl  (pin_lvl),
        .rise (pin_rise)
    );

    hspc_decode u_decode (
        .mode(mode),
        .lvl (pin_lvl),
        .rise(pin_rise),
        .req (req)
    );

    always_comb begin
        st_d     = st_q;
        st_d.ovf = 1'b0;
        st_d.unf = 1'b0;
        bidir    = (mode[2:1] != 2'd0);
        up_val   = st_q.acc + 1'b1;
        dn_val   = st_q.acc - 1'b1;

        if (load) begin
            st_d.acc = load_val;
        end else if (req.zero) begin
            st_d.acc = '0;
        end else if (en && !req.hold) begin
            if (req.inc) begin
                st_d.ovf = (st_q.acc == ACC_MAX);
                st_d.acc = (!bidir && up_val == hi_preset) ? '0 : up_val;
            end else if (req.dec) begin
                st_d.unf = (st_q.acc == ACC_MIN);
                st_d.acc = dn_val;
            end
        end

        st_d.hi = bidir && (st_d.acc >= hi_preset);
        st_d.lo = bidir && (st_d.acc <= lo_preset);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc     = st_q.acc;
    assign hi_flag = st_q.hi;
    assign lo_flag = st_q.lo;
    assign ovf     = st_q.ovf;
    assign unf     = st_q.unf;
endmodule

// File: rtl/hspc_checker.sv
module hspc_checker #(
    parameter int ACC_W = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    en,
    input logic [2:0]              mode,
    input logic                    load,
    input logic signed [ACC_W-1:0] load_val,
    input logic signed [ACC_W-1:0] acc,
    input logic                    hi_flag,
    input logic                    lo_flag,
    input logic                    ovf,
    input logic                    unf
);
    localparam logic signed [ACC_W-1:0] C_MAX = $signed({1'b0, {(ACC_W-1){1'b1}}});
    localparam logic signed [ACC_W-1:0] C_MIN = $signed({1'b1, {(ACC_W-1){1'b0}}});

    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(load) && acc != $past(acc)) |->
            (acc == $past(acc) + 1'b1 || acc == $past(acc) - 1'b1 || acc == '0)); // R2

    AST_UP_FLAGS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode[2:1]) == 2'd0) |-> (!hi_flag && !lo_flag)); // R10

    AST_OVF_FROM_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> ($past(acc) == C_MAX && !unf)); // R11

    AST_UNF_FROM_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        unf |-> ($past(acc) == C_MIN && acc == C_MAX)); // R12

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(load) |-> (acc == $past(load_val))); // R13

    AST_DISABLED_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!en) && !$past(load)) |-> (acc == $past(acc) || acc == '0)); // R9
endmodule

bind hs_pulse_counter hspc_checker #(.ACC_W(ACC_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .mode    (mode),
    .load    (load),
    .load_val(load_val),
    .acc     (acc),
    .hi_flag (hi_flag),
    .lo_flag (lo_flag),
    .ovf     (ovf),
    .unf     (unf)
);

// File: tb/hs_pulse_counter_test.sv
module hs_pulse_counter_test;
    logic               clk = 1'b0;
    logic               rst_n;
    logic               en;
    logic [2:0]         mode;
    logic [3:0]         pins;
    logic signed [15:0] hi_p, lo_p, load_val;
    logic               load;
    logic signed [15:0] acc;
    logic               hi_flag, lo_flag, ovf, unf;

    int  n_chk  = 0;
    int  n_err  = 0;
    bit  done   = 1'b0;

    always #5 clk = ~clk;

    hs_pulse_counter uut (
        .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .pins(pins),
        .hi_preset(hi_p), .lo_preset(lo_p), .load(load), .load_val(load_val),
        .acc(acc), .hi_flag(hi_flag), .lo_flag(lo_flag), .ovf(ovf), .unf(unf)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_load(input int v);
        @(negedge clk);
        load = 1'b1; load_val = 16'(v);
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic pulse(input int p);
        @(negedge clk);
        pins[p] = 1'b1;
        repeat (2) @(negedge clk);
        pins[p] = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 acc", int'(acc), 0);
        chk("R1 flags", {hi_flag, lo_flag, ovf, unf}, 0);
    endtask

    task automatic t_up;
        mode = 3'd0; hi_p = 16'sd1000;
        do_load(4);
        @(negedge clk); pins[0] = 1'b1;
        repeat (2) @(negedge clk);
        chk("R2 latency early", int'(acc), 4);
        @(negedge clk);
        chk("R2 latency due", int'(acc), 5);
        pins[0] = 1'b0; repeat (3) @(negedge clk);
        pulse(1); pulse(2); pulse(3);
        chk("R2 other pins ignored", int'(acc), 5);
        pulse(0);
        chk("R2 second count", int'(acc), 6);
    endtask

    task automatic t_up_clear;
        mode = 3'd0; hi_p = 16'sd3;
        do_load(1);
        pulse(0);
        chk("R3 below preset", int'(acc), 2);
        pulse(0);
        chk("R3 clear at preset", int'(acc), 0);
        chk("R10 up mode flags", {hi_flag, lo_flag}, 0);
    endtask

    task automatic t_dir;
        mode = 3'd2; hi_p = 16'sd100; lo_p = -16'sd100;
        do_load(10);
        pulse(0);
        chk("R4 dir low up", int'(acc), 11);
        @(negedge clk); pins[1] = 1'b1;
        pulse(0); pulse(0);
        chk("R4 dir high down", int'(acc), 9);
        pins[1] = 1'b0;
    endtask

    task automatic t_updn;
        mode = 3'd4;
        do_load(0);
        pulse(0);
        chk("R5 up pin", int'(acc), 1);
        pulse(1); pulse(1);
        chk("R5 down pin", int'(acc), -1);
        @(negedge clk); pins[1:0] = 2'b11;
        repeat (2) @(negedge clk); pins[1:0] = 2'b00;
        repeat (4) @(negedge clk);
        chk("R5 both cancel", int'(acc), -1);
    endtask

    task automatic t_quad;
        mode = 3'd6;
        do_load(0);
        pulse(0);
        chk("R6 A with B low", int'(acc), 1);
        pulse(1);
        chk("R6 B alone", int'(acc), 1);
        @(negedge clk); pins[1] = 1'b1;
        pulse(0); pulse(0);
        chk("R6 A with B high", int'(acc), -1);
        pins[1] = 1'b0;
    endtask

    task automatic t_zero_pin;
        mode = 3'd1; hi_p = 16'sd1000;
        do_load(7);
        @(negedge clk); en = 1'b0;
        pulse(2);
        chk("R7 zero edge while disabled", int'(acc), 0);
        en = 1'b1;
        mode = 3'd2;
        do_load(7);
        pulse(2);
        chk("R7 zero pin ignored plain", int'(acc), 7);
    endtask

    task automatic t_hold;
        mode = 3'd5;
        do_load(3);
        @(negedge clk); pins[3] = 1'b1;
        pulse(0);
        chk("R8 hold blocks", int'(acc), 3);
        mode = 3'd4;
        pulse(0);
        chk("R8 hold ignored plain", int'(acc), 4);
        @(negedge clk); pins[3] = 1'b0;
    endtask

    task automatic t_enable;
        mode = 3'd2; hi_p = 16'sd10; lo_p = -16'sd10;
        do_load(0);
        @(negedge clk);
        chk("R10 between presets", {hi_flag, lo_flag}, 0);
        en = 1'b0;
        pulse(0);
        chk("R9 no count when disabled", int'(acc), 0);
        hi_p = 16'sd0;
        @(negedge clk);
        chk("R9 flag follows preset", int'(hi_flag), 1);
        en = 1'b1;
    endtask

    task automatic t_flags;
        mode = 3'd4; hi_p = 16'sd5; lo_p = -16'sd3;
        do_load(4);
        chk("R10 below high", int'(hi_flag), 0);
        pulse(0);
        chk("R10 at high", int'(hi_flag), 1);
        do_load(-3);
        chk("R10 at low", {hi_flag, lo_flag}, 1);
        pulse(0);
        chk("R10 above low", int'(lo_flag), 0);
    endtask

    task automatic t_ovf;
        mode = 3'd4; hi_p = 16'sd0; lo_p = 16'sd0;
        do_load(32767);
        @(negedge clk); pins[0] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R11 ovf pulse", int'(ovf), 1);
        chk("R11 wrap value", int'(acc), -32768);
        @(negedge clk);
        chk("R11 ovf one cycle", int'(ovf), 0);
        pins[0] = 1'b0; repeat (3) @(negedge clk);
    endtask

    task automatic t_unf;
        mode = 3'd4;
        do_load(-32768);
        @(negedge clk); pins[1] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R12 unf pulse", int'(unf), 1);
        chk("R12 wrap value", int'(acc), 32767);
        @(negedge clk);
        chk("R12 unf one cycle", int'(unf), 0);
        pins[1] = 1'b0; repeat (3) @(negedge clk);
    endtask

    task automatic t_load;
        mode = 3'd0; hi_p = 16'sd1000;
        do_load(0);
        @(negedge clk); pins[0] = 1'b1;
        repeat (2) @(negedge clk);
        load = 1'b1; load_val = 16'sd77;
        @(negedge clk);
        load = 1'b0;
        chk("R13 load beats count", int'(acc), 77);
        pins[0] = 1'b0; repeat (3) @(negedge clk);
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        rst_n = 1'b0; en = 1'b1; mode = 3'd0; pins = 4'd0;
        hi_p = 16'sd1000; lo_p = 16'sd0; load = 1'b0; load_val = 16'sd0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_up();
        t_up_clear();
        t_dir();
        t_updn();
        t_quad();
        t_zero_pin();
        t_hold();
        t_enable();
        t_flags();
        t_ovf();
        t_unf();
        t_load();
        done = 1'b1;
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
        end
    end
endmodule